// File: doc/BRIEF.md
# System-Control Status and Cause Register Block

This block holds the two system-control registers of a small 32-bit RISC core: a Status word and a Cause word. It also holds a bank of spare control registers. Software reaches every register by index. A move-to operation writes a register, and a move-from operation reads one. Both move-from forms share a single read port that returns the addressed register.

A return-from-exception strobe pops the mode and interrupt-enable stack that sits in the low six bits of Status. The stack has three levels of two bits each, and the pop moves each level down by one.

After any write to Status or Cause, the block checks whether a software interrupt is pending. A request needs a software-pending bit in Cause that is also enabled in Status, together with the global enable. When the request holds, the block raises an exception request for one cycle and presents the Cause value alongside it.

Top module: `cp0_ctrl_regs`

## Requirements
- R1: After reset, reads of Status (index 12), Cause (index 13) and every spare index return zero, and no exception request is asserted.
- R2: A write to index 12 loads all 32 bits of the write data into Status. The new value is readable from the clock edge that follows.
- R3: A write to index 13 stores the write data into Cause with bits 15:10 forced to zero. All other bits are kept as written.
- R4: A write to any index other than 12 or 13 stores the data unmodified, and a later read of that index returns it.
- R5: The read port returns the register selected by the read index in the same cycle, with no added latency.
- R6: On a return-from-exception strobe, Status bits 3:0 take the previous value of bits 5:2. Bits 31:4 are unchanged.
- R7: When a write to index 12 and a return-from-exception strobe arrive in the same cycle, the write value wins.
- R8: In the cycle after a write to Status or Cause, the exception request is asserted if (Cause AND Status AND 0x300) is nonzero and Status bit 0 is set. The request lasts one cycle, and the request-cause output then equals Cause.
- R9: No exception request is raised after a write to a spare index, after a strobe alone, or when the enable or mask condition of R8 fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Move-to write enable |
| wr_idx | input | 5 | Register index for the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 5 | Register index for the read |
| rd_data | output | 32 | Value of the addressed register |
| rfe | input | 1 | Return-from-exception strobe (stack pop) |
| swi_req | output | 1 | Software-interrupt exception request, one cycle |
| swi_cause | output | 32 | Cause value that accompanies the request |

## Verification
The bench loads Status with a value whose interrupt-stack bits differ in every position. It then applies two pops in a row, so that a wrong pop direction or a damaged upper field shows up as a distinct value. Cause is written with all ones, which reveals whether the hardware-pending field is cleared and nothing else. The software-interrupt check is driven with several patterns: an enabled mask bit with a matching pending bit, a pending bit that is not masked, a global enable that is off, and a write to a spare index. Together these separate the three terms of the request condition and show which writes trigger the check. A write and a pop in the same cycle show which of the two takes priority.

// File: rtl/cp0_ctrl_pkg.sv
package cp0_ctrl_pkg;
   localparam int unsigned CP0_DATA_W = 32;
   localparam int unsigned CP0_IDX_W  = 5;
   localparam int unsigned CP0_STAT   = 12;
   localparam int unsigned CP0_CAUSE  = 13;

   // one-hot write decode shared by the sub-blocks
   typedef struct packed {
      logic stat;
      logic cause;
      logic spare;
   } cp0_wsel_t;
endpackage

// File: rtl/cp0_stat_unit.sv
module cp0_stat_unit
   import cp0_ctrl_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned STACK_LVL = 3,
   parameter int unsigned LVL_W     = 2,
   parameter logic [DATA_W-1:0] HOLD_MASK = 32'h0000_FC00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cp0_wsel_t         wsel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rfe,
   output logic [DATA_W-1:0] status_q,
   output logic [DATA_W-1:0] cause_q
);
   localparam int unsigned STK_W = STACK_LVL * LVL_W;
   localparam int unsigned POP_W = (STACK_LVL - 1) * LVL_W;

   if (STACK_LVL < 2) begin : g_bad_lvl
      $error("STACK_LVL must be at least 2");
   end
   if (STK_W >= DATA_W) begin : g_bad_stk
      $error("mode stack does not fit in DATA_W");
   end

   logic [DATA_W-1:0] popped;
   assign popped = {status_q[DATA_W-1:POP_W], status_q[STK_W-1:LVL_W]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         cause_q  <= '0;
      end else begin
         if (wsel.stat)
            status_q <= wr_data;
         else if (rfe)
            status_q <= popped;
         if (wsel.cause)
            cause_q <= wr_data & ~HOLD_MASK;
      end
   end
endmodule

// File: rtl/cp0_spare_bank.sv
module cp0_spare_bank #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned IDX_W      = 5,
   parameter int unsigned STAT_IDX   = 12,
   parameter int unsigned CAUSE_IDX  = 13,
   parameter bit          KEEP_SPARE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] spare_q [1<<IDX_W]
);
   localparam int unsigned NREG = 1 << IDX_W;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (KEEP_SPARE && g != STAT_IDX && g != CAUSE_IDX) begin : g_store
         always_ff @(posedge clk) begin
            if (!rst_n)
               spare_q[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
               spare_q[g] <= wr_data;
         end
      end else begin : g_zero
         assign spare_q[g] = '0;
      end
   end
endmodule

// File: rtl/cp0_swi_eval.sv
module cp0_swi_eval #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IE_BIT   = 0,
   parameter logic [DATA_W-1:0] SWI_MASK = 32'h0000_0300
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic [DATA_W-1:0] status_q,
   input  logic [DATA_W-1:0] cause_q,
   output logic              swi_req
);
   if (IE_BIT >= DATA_W) begin : g_bad_ie
      $error("IE_BIT outside DATA_W");
   end

   logic chk_q;
   always_ff @(posedge clk) begin
      if (!rst_n) chk_q <= 1'b0;
      else        chk_q <= trig;
   end

   assign swi_req = chk_q && status_q[IE_BIT] && (|(status_q & cause_q & SWI_MASK));
endmodule

// File: rtl/cp0_ctrl_regs.sv
module cp0_ctrl_regs
   import cp0_ctrl_pkg::*;
#(
   parameter int unsigned DATA_W     = CP0_DATA_W,
   parameter int unsigned IDX_W      = CP0_IDX_W,
   parameter int unsigned STAT_IDX   = CP0_STAT,
   parameter int unsigned CAUSE_IDX  = CP0_CAUSE,
   parameter bit          KEEP_SPARE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   input  logic              rfe,
   output logic              swi_req,
   output logic [DATA_W-1:0] swi_cause
);
   localparam int unsigned NREG = 1 << IDX_W;

   if (STAT_IDX >= NREG || CAUSE_IDX >= NREG || STAT_IDX == CAUSE_IDX) begin : g_bad_idx
      $error("Status/Cause indices invalid for IDX_W");
   end

   cp0_wsel_t         wsel;
   logic [DATA_W-1:0] status_q, cause_q;
   logic [DATA_W-1:0] spare_q [NREG];

   always_comb begin
      wsel.stat  = wr_en && (wr_idx == IDX_W'(STAT_IDX));
      wsel.cause = wr_en && (wr_idx == IDX_W'(CAUSE_IDX));
      wsel.spare = wr_en && !wsel.stat && !wsel.cause;
   end

   cp0_stat_unit #(.DATA_W(DATA_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .wsel(wsel), .wr_data(wr_data), .rfe(rfe),
      .status_q(status_q), .cause_q(cause_q));

   cp0_spare_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W), .STAT_IDX(STAT_IDX),
                    .CAUSE_IDX(CAUSE_IDX), .KEEP_SPARE(KEEP_SPARE)) u_spare (
      .clk(clk), .rst_n(rst_n), .wr_en(wsel.spare), .wr_idx(wr_idx),
      .wr_data(wr_data), .spare_q(spare_q));

   cp0_swi_eval #(.DATA_W(DATA_W)) u_swi (
      .clk(clk), .rst_n(rst_n), .trig(wsel.stat || wsel.cause),
      .status_q(status_q), .cause_q(cause_q), .swi_req(swi_req));

   always_comb begin
      if (rd_idx == IDX_W'(STAT_IDX))       rd_data = status_q;
      else if (rd_idx == IDX_W'(CAUSE_IDX)) rd_data = cause_q;
      else                                  rd_data = spare_q[rd_idx];
   end

   assign swi_cause = cause_q;
endmodule

// File: rtl/cp0_ctrl_chk.sv
module cp0_ctrl_chk #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned IDX_W     = 5,
   parameter int unsigned STAT_IDX  = 12,
   parameter int unsigned CAUSE_IDX = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic              rfe,
   input logic [DATA_W-1:0] status_q,
   input logic [DATA_W-1:0] cause_q,
   input logic              swi_req
);
   logic st_wr, ca_wr;
   assign st_wr = wr_en && wr_idx == IDX_W'(STAT_IDX);
   assign ca_wr = wr_en && wr_idx == IDX_W'(CAUSE_IDX);

   assert_status_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr |=> status_q == $past(wr_data));

   assert_cause_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cause_q[15:10] == 6'b0);

   assert_rfe_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rfe && !st_wr) |=> (status_q[3:0] == $past(status_q[5:2]))
                          && (status_q[DATA_W-1:4] == $past(status_q[DATA_W-1:4])));

   assert_swi_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
      swi_req |-> (status_q[0] && (|(status_q & cause_q & 32'h300))));

   assert_swi_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      swi_req |-> $past(st_wr || ca_wr));
endmodule

bind cp0_ctrl_regs cp0_ctrl_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W),
   .STAT_IDX(STAT_IDX), .CAUSE_IDX(CAUSE_IDX)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
   .rfe(rfe), .status_q(status_q), .cause_q(cause_q), .swi_req(swi_req));

// File: tb/sim_cp0_ctrl_regs.sv
`timescale 1ns/1ps
module sim_cp0_ctrl_regs;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        wr_en = 0;
   logic [4:0]  wr_idx = 0, rd_idx = 0;
   logic [31:0] wr_data = 0;
   logic        rfe = 0;
   logic [31:0] rd_data, swi_cause;
   logic        swi_req;
   int errors = 0, checks = 0;

   always #10 clk = ~clk;

   cp0_ctrl_regs u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .rfe(rfe),
      .swi_req(swi_req), .swi_cause(swi_cause));

   function automatic logic [31:0] pop_model(input logic [31:0] s);
      return {s[31:4], s[5:2]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd_chk(input string req, input logic [4:0] idx, input logic [31:0] exp);
      rd_idx = idx;
      #1 check(req, rd_data, exp);
   endtask

   // single write, returns right after the storing edge (check window open)
   task automatic wr(input logic [4:0] idx, input logic [31:0] d);
      @(negedge clk); wr_en = 1; wr_idx = idx; wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic wr_swi(input string req, input logic [4:0] idx, input logic [31:0] d,
                         input logic exp_req, input logic [31:0] exp_cause);
      wr(idx, d);
      check(req, {31'b0, swi_req}, {31'b0, exp_req});
      if (exp_req) check(req, swi_cause, exp_cause);
      @(negedge clk);
      check(req, {31'b0, swi_req}, 32'b0);
   endtask

   task automatic t_reset;
      rd_chk("R1", 5'd12, 32'h0);
      rd_chk("R1", 5'd13, 32'h0);
      rd_chk("R1", 5'd7, 32'h0);
      check("R1", {31'b0, swi_req}, 32'b0);
   endtask

   task automatic t_status;
      wr_swi("R2", 5'd12, 32'hA5A5_A5E6, 1'b0, 32'h0);
      rd_chk("R2", 5'd12, 32'hA5A5_A5E6);
   endtask

   task automatic t_cause;
      wr_swi("R3", 5'd13, 32'hFFFF_FFFF, 1'b0, 32'h0);  // IE=0 in status
      rd_chk("R3", 5'd13, 32'hFFFF_03FF);
      wr(5'd13, 32'h0);
   endtask

   task automatic t_spare;
      wr(5'd5, 32'hDEAD_BEEF);
      wr(5'd0, 32'h1234_5678);
      rd_chk("R4", 5'd5, 32'hDEAD_BEEF);
      rd_chk("R4", 5'd0, 32'h1234_5678);
      rd_idx = 5'd12;
      #1 check("R5", rd_data, 32'hA5A5_A5E6);
      rd_idx = 5'd5;
      #1 check("R5", rd_data, 32'hDEAD_BEEF);
   endtask

   task automatic t_rfe;
      logic [31:0] exp = 32'hA5A5_A5E7;
      wr(5'd12, exp);
      for (int i = 0; i < 2; i++) begin
         @(negedge clk); rfe = 1;
         @(negedge clk); rfe = 0;
         exp = pop_model(exp);
         rd_chk("R6", 5'd12, exp);
         check("R9", {31'b0, swi_req}, 32'b0);
      end
      check("R6", exp, 32'hA5A5_A5EA);
   endtask

   task automatic t_rfe_vs_write;
      @(negedge clk); rfe = 1; wr_en = 1; wr_idx = 5'd12; wr_data = 32'h0000_0030;
      @(negedge clk); rfe = 0; wr_en = 0;
      rd_chk("R7", 5'd12, 32'h0000_0030);
   endtask

   task automatic t_swi;
      wr_swi("R8", 5'd12, 32'h0000_0101, 1'b0, 32'h0);   // cause=0
      wr_swi("R8", 5'd13, 32'h0000_0100, 1'b1, 32'h0000_0100);
      wr_swi("R8", 5'd12, 32'h0000_0301, 1'b1, 32'h0000_0100);
      wr_swi("R9", 5'd5,  32'h0000_0000, 1'b0, 32'h0);    // spare write
      wr_swi("R9", 5'd12, 32'h0000_0300, 1'b0, 32'h0);    // IE off
      wr_swi("R9", 5'd12, 32'h0000_0201, 1'b0, 32'h0);    // ...
      wr_swi("R9", 5'd13, 32'h0000_0400, 1'b0, 32'h0);    // unmasked / cleared bit
      wr_swi("R8", 5'd13, 32'h0000_0200, 1'b1, 32'h0000_0200);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_status();
      t_cause();
      t_spare();
      t_rfe();
      t_rfe_vs_write();
      t_swi();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule